// File: doc/BRIEF.md
# Multi-Lane Deterministic Traffic Generator

This block produces a self-describing stream of test words for a multi-lane streaming link. On each transfer cycle it presents one 64-bit sample word per lane, side by side on a wide data bus. Each word carries its lane index, a running burst number and a running word number. A receiver can therefore check ordering, dropped words and lane-to-lane alignment as well as payload integrity.

A static mode input selects between pure streaming, with no framing at all, and framed operation. In framed operation the stream is cut into bursts of a programmable number of beats. The block marks the first and last beat, carries a channel field and a last-word byte count, and raises a pseudo-random user-command flag on some burst openings. Transfers follow a valid/ready handshake: a stalled word is held unchanged. An enable input starts and stops generation without disturbing the running counts.

Top module: `mltg_traffic_gen`

## Requirements
- R1: Lane `l` occupies `out_data[64*l+63 : 64*l]`. Within each lane word, bits 63..59 hold the lane index `l`, bits 58..32 hold the burst number and bits 31..0 hold the word number. All lanes of one beat carry the same burst number and word number.
- R2: The burst number is 1 after reset. In framed mode, each burst opening after the first carries the previous burst number plus one. In streaming mode it stays 1.
- R3: The word number of the first transferred beat after reset is 0. It rises by one with every transfer and is never cleared at burst boundaries.
- R4: A transfer happens only in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` keep their values into the next cycle.
- R5: With `framed_mode` low, `out_sob`, `out_eob`, `out_cmd`, `out_chan` and `out_nbytes` are all zero.
- R6: With `framed_mode` high, `out_sob` marks the first beat of a burst and `out_eob` marks beat number `burst_len`. The beat after an `out_eob` transfer opens a new burst. A `burst_len` of 0 or 1 gives single-beat bursts with both flags set.
- R7: `out_cmd` is only ever high together with `out_sob`. Its value is bit 15 of a 16-bit register that starts at `SEED` (default 16'hACE1). The register shifts left once per transfer that carries `out_sob`, and its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R8: In framed mode, `out_chan` equals the low 8 bits of the burst number. `out_nbytes` is 8 on beats that carry `out_eob` and 0 on all other beats.
- R9: `out_valid` rises on the clock edge after `gen_en` is first sampled high. After `gen_en` goes low, `out_valid` falls on the next edge unless a word is stalled. Pausing keeps the burst number, word number and beat position.
- R10: While `rst_n` is low, `out_valid` is low. Reset release passes through a two-stage synchronizer before generation can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generation enable |
| framed_mode | input | 1 | 1 selects framed bursts, 0 selects pure streaming (static) |
| burst_len | input | LEN_W | Beats per burst in framed mode (0 treated as 1) |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Beat valid |
| out_data | output | LANES*64 | Concatenated lane sample words |
| out_sob | output | 1 | First beat of burst |
| out_eob | output | 1 | Last beat of burst |
| out_cmd | output | 1 | User-command flag |
| out_chan | output | 8 | Channel field |
| out_nbytes | output | 4 | Valid bytes in the last word |

## Verification
The bench builds the block with three lanes and a 4-bit burst length. The odd, non-power-of-two lane count exercises lane placement away from neat boundaries. The narrow length field lets a burst-length sweep from 0 and 1 up to 15 run in a short time. Irregular ready and enable patterns pause the stream mid-burst and on burst edges, so counter continuity, stall hold and the per-burst pseudo-random command sequence are all compared against an independent model over many bursts.

// File: rtl/mltg_pkg.sv
package mltg_pkg;
  localparam int WORD_W   = 64;
  localparam int ID_W     = 5;
  localparam int BNUM_W   = 27;
  localparam int WNUM_W   = 32;
  localparam int CHAN_W   = 8;
  localparam int NBYTES_W = 4;
  localparam int MAX_LANES = 8;
  localparam logic [NBYTES_W-1:0] FULL_WORD_BYTES = NBYTES_W'(WORD_W / 8);

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [ID_W-1:0]   lane,
    input logic [BNUM_W-1:0] bnum,
    input logic [WNUM_W-1:0] wnum
  );
    return {lane, bnum, wnum};
  endfunction
endpackage

// File: rtl/mltg_prng.sv
module mltg_prng #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic bit_out
);
  logic [15:0] state_q, state_d;
  logic        fb;

  always_comb begin
    fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
    state_d = state_q;
    if (step) state_d = {state_q[14:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign bit_out = state_q[15];
endmodule

// File: rtl/mltg_seq.sv
module mltg_seq
  import mltg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              framed,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              ready,
  output logic              valid,
  output logic              first_beat,
  output logic              last_beat,
  output logic              xfer,
  output logic [BNUM_W-1:0] bnum,
  output logic [WNUM_W-1:0] wnum
);
  logic              valid_q, valid_d;
  logic [LEN_W-1:0]  beat_q, beat_d;
  logic [BNUM_W-1:0] bnum_q, bnum_d;
  logic [WNUM_W-1:0] wnum_q, wnum_d;
  logic [LEN_W-1:0]  final_beat;
  logic              at_first, at_last;

  always_comb begin
    final_beat = (burst_len == '0) ? '0 : burst_len - 1'b1;
    at_first   = (beat_q == '0);
    at_last    = (beat_q == final_beat);
    xfer       = valid_q & ready;
  end

  always_comb begin
    valid_d = (valid_q & ~ready) | gen_en;
    beat_d  = beat_q;
    bnum_d  = bnum_q;
    wnum_d  = wnum_q;
    if (xfer) begin
      wnum_d = wnum_q + 1'b1;
      if (framed) begin
        if (at_last) begin
          beat_d = '0;
          bnum_d = bnum_q + 1'b1;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      bnum_q  <= BNUM_W'(1);
      wnum_q  <= '0;
    end else begin
      valid_q <= valid_d;
      beat_q  <= beat_d;
      bnum_q  <= bnum_d;
      wnum_q  <= wnum_d;
    end
  end

  assign valid      = valid_q;
  assign first_beat = valid_q & framed & at_first;
  assign last_beat  = valid_q & framed & at_last;
  assign bnum       = bnum_q;
  assign wnum       = wnum_q;
endmodule

// File: rtl/mltg_lane_pack.sv
module mltg_lane_pack
  import mltg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [BNUM_W-1:0]       bnum,
  input  logic [WNUM_W-1:0]       wnum,
  output logic [LANES*WORD_W-1:0] data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data[l*WORD_W +: WORD_W] = pack_word(ID_W'(l), bnum, wnum);
  end
endmodule

// File: rtl/mltg_traffic_gen.sv
module mltg_traffic_gen
  import mltg_pkg::*;
#(
  parameter int          LANES = 4,
  parameter int          LEN_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gen_en,
  input  logic                    framed_mode,
  input  logic [LEN_W-1:0]        burst_len,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] out_data,
  output logic                    out_sob,
  output logic                    out_eob,
  output logic                    out_cmd,
  output logic [CHAN_W-1:0]       out_chan,
  output logic [NBYTES_W-1:0]     out_nbytes
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   core_rst_n;
  logic                   valid_w, sob_w, eob_w, xfer_w, prng_bit;
  logic [BNUM_W-1:0]      bnum_w;
  logic [WNUM_W-1:0]      wnum_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[SYNC_STAGES-1];

  mltg_seq #(.LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(core_rst_n), .gen_en(gen_en), .framed(framed_mode),
    .burst_len(burst_len), .ready(out_ready), .valid(valid_w),
    .first_beat(sob_w), .last_beat(eob_w), .xfer(xfer_w),
    .bnum(bnum_w), .wnum(wnum_w)
  );

  mltg_prng #(.SEED(SEED)) prng_i (
    .clk(clk), .rst_n(core_rst_n), .step(xfer_w & sob_w), .bit_out(prng_bit)
  );

  mltg_lane_pack #(.LANES(LANES)) pack_i (
    .bnum(bnum_w), .wnum(wnum_w), .data(out_data)
  );

  always_comb begin
    out_valid  = valid_w;
    out_sob    = sob_w;
    out_eob    = eob_w;
    out_cmd    = sob_w & prng_bit;
    out_chan   = framed_mode ? bnum_w[CHAN_W-1:0] : '0;
    out_nbytes = eob_w ? FULL_WORD_BYTES : '0;
  end
endmodule

// File: rtl/mltg_traffic_gen_chk.sv
module mltg_traffic_gen_chk #(
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  framed_mode,
  input logic                  out_ready,
  input logic                  out_valid,
  input logic [LANES*64-1:0]   out_data,
  input logic                  out_sob,
  input logic                  out_eob,
  input logic                  out_cmd,
  input logic [7:0]            out_chan,
  input logic [3:0]            out_nbytes
);
  assert_cmd_needs_sob_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_cmd |-> out_sob);

  assert_stream_unframed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !framed_mode |-> (!out_sob && !out_eob && !out_cmd && out_chan == 8'd0 && out_nbytes == 4'd0));

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_word_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_valid && out_ready) |-> (out_data[31:0] == $past(out_data[31:0]) + 32'd1));

  assert_burst_follows_eob_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (framed_mode && out_valid && out_ready && out_eob) |=> (!out_valid || out_sob));

  assert_nbytes_on_eob_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_nbytes != 4'd0) |-> out_eob);
endmodule

bind mltg_traffic_gen mltg_traffic_gen_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .framed_mode(framed_mode), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .out_sob(out_sob), .out_eob(out_eob),
  .out_cmd(out_cmd), .out_chan(out_chan), .out_nbytes(out_nbytes)
);

// File: tb/mltg_traffic_gen_tb_top.sv
module mltg_traffic_gen_tb_top;
  localparam int          LANES = 3;
  localparam int          LEN_W = 4;
  localparam logic [15:0] SEED  = 16'hACE1;
  localparam int          CLK_PERIOD = 10;
  localparam int          DW = LANES * 64;

  logic clk, rst_n, gen_en, framed_mode, out_ready;
  logic [LEN_W-1:0] burst_len;
  logic out_valid, out_sob, out_eob, out_cmd;
  logic [DW-1:0] out_data;
  logic [7:0] out_chan;
  logic [3:0] out_nbytes;

  mltg_traffic_gen #(.LANES(LANES), .LEN_W(LEN_W), .SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .framed_mode(framed_mode),
    .burst_len(burst_len), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sob(out_sob), .out_eob(out_eob), .out_cmd(out_cmd),
    .out_chan(out_chan), .out_nbytes(out_nbytes)
  );

  typedef struct {
    logic [26:0] bnum;
    logic [31:0] wnum;
    logic sob, eob, cmd;
    logic [7:0] chan;
    logic [3:0] nb;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0, pops = 0;
  bit mon_on = 0, cur_framed = 0;

  logic [26:0] m_bnum;
  logic [31:0] m_wnum;
  int          m_beat;
  logic [15:0] m_lfsr;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bnum = 27'd1; m_wnum = 32'd0; m_beat = 0; m_lfsr = SEED;
    exp_q.delete();
  endtask

  task automatic push_expect(input int n, input bit fr, input int blen);
    int eff;
    exp_t e;
    eff = (blen == 0) ? 1 : blen;
    for (int i = 0; i < n; i++) begin
      e.bnum = m_bnum;
      e.wnum = m_wnum;
      e.sob  = fr && (m_beat == 0);
      e.eob  = fr && (m_beat == eff - 1);
      e.cmd  = e.sob && m_lfsr[15];
      e.chan = fr ? m_bnum[7:0] : 8'd0;
      e.nb   = e.eob ? 4'd8 : 4'd0;
      exp_q.push_back(e);
      m_wnum = m_wnum + 1;
      if (fr) begin
        if (e.sob) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        if (e.eob) begin m_beat = 0; m_bnum = m_bnum + 1; end
        else m_beat++;
      end
    end
  endtask

  // Monitor: samples late in the low phase, with the values the next edge uses
  logic [DW-1:0] held;
  bit prev_stall = 0;
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (mon_on && rst_n) begin
      if (prev_stall) begin
        check(out_valid == 1'b1, "R4", "valid held in stall", 64'(out_valid), 64'd1);
        check(out_data == held, "R4", "data held in stall", out_data[63:0], held[63:0]);
      end
      prev_stall = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected transfer", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          pops++;
          for (int l = 0; l < LANES; l++) begin
            logic [63:0] w;
            w = out_data[l*64 +: 64];
            check(w[63:59] == 5'(l), "R1", "lane index", 64'(w[63:59]), 64'(l));
            check(w[58:32] == e.bnum, "R2", "burst number", 64'(w[58:32]), 64'(e.bnum));
            check(w[31:0] == e.wnum, "R3", "word number", 64'(w[31:0]), 64'(e.wnum));
          end
          if (cur_framed) begin
            check(out_sob == e.sob, "R6", "sob", 64'(out_sob), 64'(e.sob));
            check(out_eob == e.eob, "R6", "eob", 64'(out_eob), 64'(e.eob));
            check(out_cmd == e.cmd, "R7", "cmd", 64'(out_cmd), 64'(e.cmd));
            check(out_chan == e.chan, "R8", "chan", 64'(out_chan), 64'(e.chan));
            check(out_nbytes == e.nb, "R8", "nbytes", 64'(out_nbytes), 64'(e.nb));
          end else begin
            check({out_sob, out_eob, out_cmd, out_chan, out_nbytes} == 15'd0, "R5",
                  "framing fields", 64'({out_sob, out_eob, out_cmd, out_chan, out_nbytes}), 64'd0);
          end
        end
      end
    end else begin
      prev_stall = 0;
    end
  end

  task automatic drive_step();
    @(negedge clk); #1;
  endtask

  task automatic sample_step();
    @(negedge clk); #(CLK_PERIOD/4 + 1);
  endtask

  task automatic do_reset();
    drive_step();
    mon_on = 0; rst_n = 0; gen_en = 0; out_ready = 0;
    repeat (3) drive_step();
    rst_n = 1;
    repeat (4) drive_step();
  endtask

  task automatic run_phase(input bit fr, input int blen, input int n,
                           input bit rpat, input bit gpat);
    int c;
    do_reset();
    framed_mode = fr; cur_framed = fr; burst_len = LEN_W'(blen);
    model_reset();
    push_expect(n, fr, blen);
    pops = 0;
    mon_on = 1;
    c = 0;
    while (pops < n && c < 20000) begin
      out_ready = rpat ? ((c % 3) != 1) : 1'b1;
      gen_en    = gpat ? ((c % 11) < 8) : 1'b1;
      c++;
      drive_step();
    end
    out_ready = 0; gen_en = 0;
    repeat (3) drive_step();
    check(pops == n, "R9", "transfers completed", 64'(pops), 64'(n));
    mon_on = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; gen_en = 1; out_ready = 1; framed_mode = 0; burst_len = '0;
    repeat (3) sample_step();
    check(out_valid == 1'b0, "R10", "valid low in reset", 64'(out_valid), 64'd0);
    drive_step();
    gen_en = 0; rst_n = 1;
    repeat (4) drive_step();
    check(out_valid == 1'b0, "R10", "valid low after reset", 64'(out_valid), 64'd0);
    check(out_data[31:0] == 32'd0 && out_data[58:32] == 27'd1, "R10", "initial counts",
          out_data[63:0], {5'd0, 27'd1, 32'd0});
    // enable timing
    gen_en = 1;
    sample_step();
    check(out_valid == 1'b1, "R9", "valid after enable", 64'(out_valid), 64'd1);
    drive_step();
    gen_en = 0;
    sample_step();
    check(out_valid == 1'b0, "R9", "valid after disable", 64'(out_valid), 64'd0);

    run_phase(1'b0, 3, 25, 1'b0, 1'b0);
    run_phase(1'b0, 3, 30, 1'b1, 1'b1);
    run_phase(1'b1, 4, 30, 1'b1, 1'b1);
    run_phase(1'b1, 1, 12, 1'b0, 1'b0);
    run_phase(1'b1, 0, 8, 1'b1, 1'b0);
    run_phase(1'b1, 15, 70, 1'b1, 1'b1);
    run_phase(1'b1, 2, 60, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule